// File: doc/BRIEF.md
# Toggle-Handshake Falling-Edge RAM Port with Test Sequencer

This block pairs a single-port word-wide memory with a small state-machine data-path that drives it. The data-path runs on the rising clock edge. To start an access it drives a byte address, a write-enable and, for stores, the write data, and it inverts a request flag. The memory side runs on the falling edge of the same clock. It treats an access as pending whenever its own acknowledge flag differs from the request flag. It performs exactly one read or write, then copies the request flag into the acknowledge flag. The port therefore disables itself half a cycle after being triggered. The memory array is touched from one falling-edge process only, so synthesis can map it onto a block RAM.

Because the memory works half a cycle out of phase, a store finishes inside the cycle that issued it. The word read by a load is in the read register in time for the next rising edge. The sequencer captures it there in a dedicated wait state, so a load costs two cycles. The built-in test program has three phases. It fills every word with a value derived from a seed. It reads all words back in a permuted order. It then stores a fresh value and loads the same word on the very next cycle. After that it raises `finish` and presents the sum of everything it loaded.

Top module: `toggle_ram_top`

## Requirements
- R1: While `rst` is high at a rising edge, `finish`, `ld_strobe`, `return_val` and `ld_word` all become 0. The request flag, acknowledge flag and read register also clear to 0.
- R2: The memory holds DEPTH words of DATA_W bits. Every address issued by the sequencer is a byte address with its two low bits zero, and the word used is the byte address divided by four. Slot i lives at byte address 4*i.
- R3: An access is pending exactly when the request flag and the acknowledge flag differ. The falling-edge side services it once and then makes the acknowledge flag equal to the request flag. Both flags are equal at every rising edge.
- R4: Stores take one cycle each. Counting rising edges after `rst` falls as 1, 2, …, slot i is written at edge i+1 for i = 0..DEPTH-1. The first load is issued at edge DEPTH+1.
- R5: Each load takes two cycles: issue, then capture. For load j (j = 0..DEPTH-1), `ld_strobe` is high for exactly the one cycle that follows edge DEPTH+2+2j. During that cycle `ld_word` carries the loaded word.
- R6: The value stored in slot i is seed + i*STEP (mod 2^DATA_W), with STEP = 0x9E3779B9. Load j reads slot (j*STRIDE) mod DEPTH, with STRIDE = 3.
- R7: After the read phase, the value ~(seed + (DEPTH-1)*STEP) is stored to slot DEPTH-1 and the same slot is loaded on the very next cycle. That load returns the new value, with `ld_strobe` following edge 3*DEPTH+3.
- R8: `finish` rises after edge 3*DEPTH+4 and stays high until reset. From then on, `return_val` equals the mod-2^DATA_W sum of all DEPTH+1 loaded words.
- R9: `seed` is sampled only while `rst` is high. Changes to it after reset do not affect the program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; data-path on rising edge, memory on falling edge |
| rst | input | 1 | Synchronous active-high reset |
| seed | input | DATA_W | Seed for the stored pattern, latched during reset |
| finish | output | 1 | High once the test program has ended |
| return_val | output | DATA_W | Sum of all loaded words, valid with `finish` |
| ld_strobe | output | 1 | One-cycle pulse when a load result is captured |
| ld_word | output | DATA_W | Most recently captured load result |

## Verification
The hardest case to reach from the ports is a load that directly follows a store to the same word. In that case the falling-edge side must finish the write and acknowledge it before the new request flips the flag again. The stimulus reaches this case through the program's last phase. Every seed also makes all stores run back to back, one per cycle, so the flags toggle on consecutive edges. Seeds come from a fixed-seed random stream plus the all-zeros and all-ones cases. The seed input is scrambled after reset to show that it is ignored. The bench checks every loaded word against its own model and checks the edge at which each strobe appears.

// File: rtl/toggle_ram_pkg.sv
package toggle_ram_pkg;
  typedef enum logic [2:0] {
    SEQ_FILL,
    SEQ_RD_ISSUE,
    SEQ_RD_WAIT,
    SEQ_CHK_STORE,
    SEQ_CHK_LOAD,
    SEQ_CHK_WAIT,
    SEQ_DONE
  } seq_state_e;
endpackage

// File: rtl/toggle_ram_port.sv
module toggle_ram_port #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_flag,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  word_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ack_flag,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              pending;

  assign pending = (ack_flag != req_flag);

  // single falling-edge process owns the array
  always_ff @(negedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (pending) begin
      if (wr_en) mem[word_idx] <= wr_data;
      else       rd_data <= mem[word_idx];
    end
  end

  // self-disable: catch up with the request flag
  always_ff @(negedge clk) begin
    if (rst) ack_flag <= 1'b0;
    else if (pending) ack_flag <= req_flag;
  end
endmodule

// File: rtl/toggle_ram_seq.sv
module toggle_ram_seq
  import toggle_ram_pkg::*;
#(
  parameter int              DATA_W = 32,
  parameter int              DEPTH  = 8,
  parameter int              STRIDE = 3,
  parameter logic [DATA_W-1:0] STEP = 32'h9E3779B9,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int BYTE_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] seed,
  input  logic [DATA_W-1:0] rd_data,
  output logic              req_flag,
  output logic              wr_en,
  output logic [BYTE_W-1:0] byte_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              finish,
  output logic [DATA_W-1:0] return_val,
  output logic              ld_strobe,
  output logic [DATA_W-1:0] ld_word
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  seq_state_e        state;
  logic [IDX_W-1:0]  cnt;
  logic [IDX_W-1:0]  perm;
  logic [DATA_W-1:0] seed_q;
  logic [DATA_W-1:0] acc;

  assign perm = IDX_W'(cnt * IDX_W'(STRIDE));

  function automatic logic [DATA_W-1:0] slot_val(input logic [DATA_W-1:0] s,
                                                  input logic [IDX_W-1:0] i);
    return s + DATA_W'(i) * STEP;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SEQ_FILL;
      cnt        <= '0;
      seed_q     <= seed;
      acc        <= '0;
      req_flag   <= 1'b0;
      wr_en      <= 1'b0;
      byte_addr  <= '0;
      wr_data    <= '0;
      finish     <= 1'b0;
      return_val <= '0;
      ld_strobe  <= 1'b0;
      ld_word    <= '0;
    end else begin
      ld_strobe <= 1'b0;
      unique case (state)
        SEQ_FILL: begin
          req_flag  <= ~req_flag;
          wr_en     <= 1'b1;
          byte_addr <= {cnt, 2'b00};
          wr_data   <= slot_val(seed_q, cnt);
          cnt       <= cnt + 1'b1;
          if (cnt == LAST) state <= SEQ_RD_ISSUE;
        end
        SEQ_RD_ISSUE: begin
          req_flag  <= ~req_flag;
          wr_en     <= 1'b0;
          byte_addr <= {perm, 2'b00};
          state     <= SEQ_RD_WAIT;
        end
        SEQ_RD_WAIT: begin
          ld_word   <= rd_data;
          ld_strobe <= 1'b1;
          acc       <= acc + rd_data;
          cnt       <= cnt + 1'b1;
          state     <= (cnt == LAST) ? SEQ_CHK_STORE : SEQ_RD_ISSUE;
        end
        SEQ_CHK_STORE: begin
          req_flag  <= ~req_flag;
          wr_en     <= 1'b1;
          byte_addr <= {LAST, 2'b00};
          wr_data   <= ~slot_val(seed_q, LAST);
          state     <= SEQ_CHK_LOAD;
        end
        SEQ_CHK_LOAD: begin
          req_flag  <= ~req_flag;
          wr_en     <= 1'b0;
          byte_addr <= {LAST, 2'b00};
          state     <= SEQ_CHK_WAIT;
        end
        SEQ_CHK_WAIT: begin
          ld_word   <= rd_data;
          ld_strobe <= 1'b1;
          acc       <= acc + rd_data;
          state     <= SEQ_DONE;
        end
        default: begin
          finish     <= 1'b1;
          return_val <= acc;
        end
      endcase
    end
  end
endmodule

// File: rtl/toggle_ram_top.sv
module toggle_ram_top #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int STRIDE = 3,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int BYTE_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] seed,
  output logic              finish,
  output logic [DATA_W-1:0] return_val,
  output logic              ld_strobe,
  output logic [DATA_W-1:0] ld_word
);
  logic              req_flag;
  logic              ack_flag;
  logic              mem_we;
  logic [BYTE_W-1:0] mem_baddr;
  logic [IDX_W-1:0]  mem_idx;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata;

  // byte address to word index
  assign mem_idx = mem_baddr[BYTE_W-1:2];

  toggle_ram_seq #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .STRIDE(STRIDE)
  ) seq_i (
    .clk(clk), .rst(rst), .seed(seed), .rd_data(mem_rdata),
    .req_flag(req_flag), .wr_en(mem_we), .byte_addr(mem_baddr),
    .wr_data(mem_wdata), .finish(finish), .return_val(return_val),
    .ld_strobe(ld_strobe), .ld_word(ld_word)
  );

  toggle_ram_port #(
    .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) port_i (
    .clk(clk), .rst(rst), .req_flag(req_flag), .wr_en(mem_we),
    .word_idx(mem_idx), .wr_data(mem_wdata),
    .ack_flag(ack_flag), .rd_data(mem_rdata)
  );
endmodule

// File: rtl/toggle_ram_chk.sv
module toggle_ram_chk #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              req_flag,
  input logic              ack_flag,
  input logic [BYTE_W-1:0] mem_baddr,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              ld_strobe,
  input logic [DATA_W-1:0] ld_word,
  input logic              finish
);
  // R3
  flags_idle_chk: assert property (@(posedge clk) disable iff (rst)
    req_flag == ack_flag);

  // R3
  self_clear_chk: assert property (@(negedge clk) disable iff (rst)
    (req_flag != ack_flag) |=> (ack_flag == $past(req_flag)));

  // R2
  word_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    (req_flag != $past(req_flag)) |-> (mem_baddr[1:0] == 2'b00));

  // R5
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    ld_strobe |-> (ld_word == $past(mem_rdata)));

  // R8
  finish_hold_chk: assert property (@(posedge clk) disable iff (rst)
    finish |=> finish);
endmodule

bind toggle_ram_top toggle_ram_chk #(
  .DATA_W(DATA_W), .BYTE_W(BYTE_W)
) chk_i (
  .clk(clk), .rst(rst), .req_flag(req_flag), .ack_flag(ack_flag),
  .mem_baddr(mem_baddr), .mem_rdata(mem_rdata),
  .ld_strobe(ld_strobe), .ld_word(ld_word), .finish(finish)
);

// File: tb/toggle_ram_top_tb_top.sv
module toggle_ram_top_tb_top;
  localparam int N = 8;
  localparam logic [31:0] STEP = 32'h9E3779B9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] seed = '0;
  logic        finish;
  logic [31:0] return_val;
  logic        ld_strobe;
  logic [31:0] ld_word;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  toggle_ram_top dut_i (
    .clk(clk), .rst(rst), .seed(seed), .finish(finish),
    .return_val(return_val), .ld_strobe(ld_strobe), .ld_word(ld_word)
  );

  function automatic logic [31:0] exp_val(input logic [31:0] s, input int i);
    return s + 32'(i) * STEP;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_program(input logic [31:0] s);
    logic [31:0] sum;
    int          loads;
    sum   = '0;
    loads = 0;
    seed  = s;
    rst   = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(finish == 1'b0, "R1 finish", 32'(finish), 0);
    check(ld_strobe == 1'b0, "R1 ld_strobe", 32'(ld_strobe), 0);
    check(return_val == '0, "R1 return_val", return_val, 0);
    check(ld_word == '0, "R1 ld_word", ld_word, 0);
    rst = 1'b0;
    for (int k = 1; k <= 3 * N + 6; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 2) seed = ~s ^ $urandom;  // R9: ignored after reset
      if (ld_strobe) begin
        if (loads < N) begin
          // R4 R5 R6: one-cycle stores, two-cycle loads, permuted order
          check(k == N + 2 + 2 * loads, "R5 strobe edge", 32'(k), 32'(N + 2 + 2 * loads));
          check(ld_word == exp_val(s, (loads * 3) % N), "R6 load value",
                ld_word, exp_val(s, (loads * 3) % N));
          sum = sum + exp_val(s, (loads * 3) % N);
        end else if (loads == N) begin
          // R7 R3: store then load of same word on consecutive cycles
          check(k == 3 * N + 3, "R7 strobe edge", 32'(k), 32'(3 * N + 3));
          check(ld_word == ~exp_val(s, N - 1), "R7 fresh value",
                ld_word, ~exp_val(s, N - 1));
          sum = sum + ~exp_val(s, N - 1);
        end
        loads++;
      end
      if (k == 3 * N + 3) begin
        check(finish == 1'b0, "R8 finish early", 32'(finish), 0);
      end
      if (k >= 3 * N + 4) begin
        check(finish == 1'b1, "R8 finish", 32'(finish), 1);
        check(return_val == sum, "R8 return_val", return_val, sum);
      end
    end
    check(loads == N + 1, "R5 load count", 32'(loads), 32'(N + 1));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    run_program(32'h0000_0000);
    run_program(32'hFFFF_FFFF);
    // R2: word index from byte address checked through full slot coverage
    for (int r = 0; r < 6; r++) run_program($urandom);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule